// File: doc/BRIEF.md
# Cluster Bounding Box Centroid

This block collapses one cluster of hit pixels into one coordinate: the centre of the smallest axis-aligned box that encloses every hit. Hits arrive one per cycle as (row, column) pairs qualified by a valid strobe. A last flag on a hit closes the cluster. While a cluster is open, the block keeps the smallest and largest row and the smallest and largest column seen so far.

When the closing hit is accepted, the block emits the box centre for each axis in half-pixel fixed point, together with a one-cycle valid pulse. Pixel index `i` is taken to lie at coordinate `i + 0.5`. The emitted value is therefore `(min + max)/2 + 0.5`, carried as an integer count of half pixels that equals `min + max + 1`.

Several copies can be placed side by side on separate hit streams, because an instance shares no state with any other. A controller with two named states sequences the work:
- `ST_IDLE`: no cluster is open.
- `ST_OPEN`: a cluster has hits but is not yet closed.

The transitions are:
- `open` (ST_IDLE to ST_OPEN): a valid hit arrives without last.
- `single` (ST_IDLE to ST_IDLE): a valid hit arrives with last.
- `grow` (ST_OPEN to ST_OPEN): a valid hit arrives without last, or there is an idle cycle.
- `close` (ST_OPEN to ST_IDLE): a valid hit arrives with last.

Top module: `cbc_centroid`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and no cluster is open.
- R2: The first valid hit after a cluster closes sets all four extremes from that hit alone. No coordinate of an earlier cluster affects the new result.
- R3: Across the hits of a cluster, arriving in any order, the block keeps the smallest and largest row and the smallest and largest column.
- R4: Each centre output is `W+1` bits wide and counts half pixels, so bit 0 weighs 0.5 pixel. Its value is `min + max + 1`, which is always at least 1.
- R5: `out_valid` is high for exactly the one cycle that follows the clock edge accepting a valid hit with `hit_last` = 1. It is low in every other cycle.
- R6: A cluster of one pixel at (r, c) yields a row centre of `2r+1` and a column centre of `2c+1`.
- R7: A new cluster may start in the cycle right after a closing hit. Its result does not depend on the previous cluster.
- R8: Cycles with `hit_valid` = 0 inside a cluster change neither the extremes nor the output. Inputs presented in such cycles are ignored.
- R9: Coordinates at 0 and at the largest index, `2^W-1`, produce exact centres with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Hit present this cycle |
| hit_row | input | ROW_W | Row index of the hit |
| hit_col | input | COL_W | Column index of the hit |
| hit_last | input | 1 | Hit closes its cluster |
| out_valid | output | 1 | Centre valid pulse |
| ctr_row | output | ROW_W+1 | Row centre in half pixels |
| ctr_col | output | COL_W+1 | Column centre in half pixels |

## Verification
The bench drives the following stimulus:
- Single-pixel clusters, which separate the `single` path from `open`/`close`.
- Multi-hit clusters whose extremes arrive first, last and in the middle of the cluster, which catch a comparison that is inverted or skipped.
- Idle gaps carrying junk coordinates, which show whether invalid cycles leak into the extremes.
- Clusters placed back to back with no gap, which reveal any state carried between clusters.
- Hits at index 0 and at the top index, which expose wrap in the centre sum.

A behavioural model predicts `out_valid` and both centres, and the bench compares them with the outputs on every cycle.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } cbc_state_e;
endpackage

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
    import cbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_valid,
    input  logic hit_last,
    output logic upd,
    output logic first,
    output logic fire,
    output logic is_open
);
    cbc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        upd     = hit_valid;
        first   = 1'b0;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                first = 1'b1;
                if (hit_valid && hit_last) begin
                    fire    = 1'b1;          // single
                    state_d = ST_IDLE;
                end else if (hit_valid) begin
                    state_d = ST_OPEN;       // open
                end
            end
            ST_OPEN: begin
                if (hit_valid && hit_last) begin
                    fire    = 1'b1;          // close
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_OPEN;       // grow
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign is_open = (state_q == ST_OPEN);

    // R1: nothing is open right after reset
    p_idle_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> state_q == ST_IDLE);
    // R7: a closing hit always returns the controller to idle
    p_close_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_last) |=> state_q == ST_IDLE);
endmodule

// File: rtl/cbc_extent.sv
module cbc_extent #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic         first,
    input  logic         is_open,
    input  logic [W-1:0] coord,
    output logic [W-1:0] lo_next,
    output logic [W-1:0] hi_next
);
    logic [W-1:0] lo_q, hi_q;

    always_comb begin
        if (first) begin
            lo_next = coord;
            hi_next = coord;
        end else begin
            lo_next = (coord < lo_q) ? coord : lo_q;
            hi_next = (coord > hi_q) ? coord : hi_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (upd) begin
            lo_q <= lo_next;
            hi_q <= hi_next;
        end
    end

    // R3: the stored extremes stay ordered while a cluster is open
    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_open |-> lo_q <= hi_q);
    // R8: an idle cycle leaves the extremes untouched
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/cbc_midpoint.sv
module cbc_midpoint #(
    parameter int ROW_W = 8,
    parameter int COL_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fire,
    input  logic [ROW_W-1:0] row_lo,
    input  logic [ROW_W-1:0] row_hi,
    input  logic [COL_W-1:0] col_lo,
    input  logic [COL_W-1:0] col_hi,
    output logic           out_valid,
    output logic [ROW_W:0] ctr_row,
    output logic [COL_W:0] ctr_col
);
    localparam int RO = ROW_W + 1;
    localparam int CO = COL_W + 1;

    logic [RO-1:0] row_sum;
    logic [CO-1:0] col_sum;

    // half-pixel units: (lo+0.5 + hi+0.5)/2 * 2 = lo + hi + 1
    assign row_sum = {1'b0, row_lo} + {1'b0, row_hi} + RO'(1);
    assign col_sum = {1'b0, col_lo} + {1'b0, col_hi} + CO'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            ctr_row   <= '0;
            ctr_col   <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                ctr_row <= row_sum;
                ctr_col <= col_sum;
            end
        end
    end

    // R4: a centre is never below the first half pixel
    p_lower_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ctr_row != '0 && ctr_col != '0));
endmodule

// File: rtl/cbc_centroid.sv
module cbc_centroid #(
    parameter int ROW_W = 8,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid,
    input  logic [ROW_W-1:0] hit_row,
    input  logic [COL_W-1:0] hit_col,
    input  logic             hit_last,
    output logic             out_valid,
    output logic [ROW_W:0]   ctr_row,
    output logic [COL_W:0]   ctr_col
);
    logic upd, first, fire, is_open;
    logic [ROW_W-1:0] row_lo, row_hi;
    logic [COL_W-1:0] col_lo, col_hi;

    cbc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_last(hit_last),
        .upd(upd), .first(first), .fire(fire), .is_open(is_open)
    );

    cbc_extent #(.W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .upd(upd), .first(first), .is_open(is_open),
        .coord(hit_row), .lo_next(row_lo), .hi_next(row_hi)
    );

    cbc_extent #(.W(COL_W)) u_col (
        .clk(clk), .rst_n(rst_n), .upd(upd), .first(first), .is_open(is_open),
        .coord(hit_col), .lo_next(col_lo), .hi_next(col_hi)
    );

    cbc_midpoint #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mid (
        .clk(clk), .rst_n(rst_n), .fire(fire),
        .row_lo(row_lo), .row_hi(row_hi), .col_lo(col_lo), .col_hi(col_hi),
        .out_valid(out_valid), .ctr_row(ctr_row), .ctr_col(ctr_col)
    );

    // R5: a valid pulse follows only an accepted closing hit
    p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(hit_valid && hit_last));
    // R6: a lone pixel opened from idle yields its own centre
    p_single_pixel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_last && !is_open) |=>
        (ctr_row == {$past(hit_row), 1'b1} && ctr_col == {$past(hit_col), 1'b1}));
endmodule

// File: tb/test_cbc_centroid.sv
module test_cbc_centroid;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 8;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hit_valid = 1'b0;
    logic [RW-1:0] hit_row = '0;
    logic [CW-1:0] hit_col = '0;
    logic hit_last = 1'b0;
    logic out_valid;
    logic [RW:0] ctr_row;
    logic [CW:0] ctr_col;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    bit m_open = 0;
    int m_rlo, m_rhi, m_clo, m_chi;
    bit e_valid = 0;
    int e_row = 0, e_col = 0;
    string e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    cbc_centroid #(.ROW_W(RW), .COL_W(CW)) i_cbc_centroid (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_row(hit_row),
        .hit_col(hit_col), .hit_last(hit_last), .out_valid(out_valid),
        .ctr_row(ctr_row), .ctr_col(ctr_col)
    );

    task automatic check_out();
        checks++;
        if (out_valid !== e_valid) begin
            failures++;
            $display("FAIL %s out_valid actual=%0d expected=%0d", e_tag, out_valid, e_valid);
        end else if (e_valid && (int'(ctr_row) != e_row || int'(ctr_col) != e_col)) begin
            failures++;
            $display("FAIL %s centre actual=(%0d,%0d) expected=(%0d,%0d)",
                     e_tag, ctr_row, ctr_col, e_row, e_col);
        end
    endtask

    // check previous effect, then model and drive the next input
    task automatic step(bit v, int r, int c, bit l, string tag);
        @(negedge clk);
        check_out();
        e_valid = 0;
        e_tag = tag;
        if (v) begin
            if (!m_open) begin
                m_rlo = r; m_rhi = r; m_clo = c; m_chi = c;
            end else begin
                if (r < m_rlo) m_rlo = r;
                if (r > m_rhi) m_rhi = r;
                if (c < m_clo) m_clo = c;
                if (c > m_chi) m_chi = c;
            end
            if (l) begin
                e_valid = 1;
                e_row = m_rlo + m_rhi + 1;
                e_col = m_clo + m_chi + 1;
                m_open = 0;
            end else begin
                m_open = 1;
            end
        end
        hit_valid = v;
        hit_row = RW'(r);
        hit_col = CW'(c);
        hit_last = l;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        e_tag = "R1";
        check_out();
        rst_n = 1'b1;
        step(0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, "R1");
        // R6: single pixel
        step(1, 5, 9, 1, "R6");
        step(0, 0, 0, 0, "R6");
        // R3: extremes arrive in varied order
        step(1, 10, 20, 0, "R3");
        step(1, 14, 18, 0, "R3");
        step(1, 8, 25, 0, "R3");
        step(1, 12, 22, 1, "R3");
        step(0, 0, 0, 0, "R5");
        // R8: idle gaps with junk coordinates
        step(1, 30, 30, 0, "R8");
        step(0, 0, 255, 1, "R8");
        step(0, 255, 0, 0, "R8");
        step(1, 31, 33, 1, "R8");
        // R7 and R2: back to back clusters, no gap
        step(1, 100, 100, 0, "R2");
        step(1, 104, 96, 1, "R7");
        step(1, 2, 3, 0, "R2");
        step(1, 4, 3, 1, "R7");
        step(1, 200, 150, 1, "R7");
        // R9: index boundaries
        step(1, 0, 255, 0, "R9");
        step(1, 255, 0, 1, "R9");
        step(1, 255, 255, 1, "R9");
        step(1, 0, 0, 1, "R9");
        // R4: even and odd half-pixel results
        step(1, 3, 4, 0, "R4");
        step(1, 6, 4, 1, "R4");
        step(0, 0, 0, 0, "R5");
        // R5: a long cluster pulses once at the end
        for (int k = 0; k < 20; k++) step(1, (k * 37) % 256, (k * 91) % 256, k == 19, "R5");
        step(0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, "R5");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule